// File: doc/BRIEF.md
# Dual-Bus Ready Synchronizer

This block merges the ready requests of two system buses into one ready signal for a processor. Each bus supplies a ready line and an active-low enable. A ready line counts only while its own enable is asserted. The qualified requests are ORed into a single internal request. That request then passes through a synchronizer whose depth depends on two things: the direction of the edge and a mode select.

With the mode select low, the block serves asynchronous devices. An asserting request is first registered on a rising clock edge and then on the next falling edge. A deasserting request reaches the falling-edge register directly, so not-ready shows up one stage sooner than ready does. With the mode select high, the block serves devices that already meet setup timing. The rising-edge register is bypassed and both edge directions are taken only at the falling edge. The mode select may differ on every bus cycle. The output always comes straight from the falling-edge register. In a single-bus system, the unused enable is tied inactive (high).

Top module: `rdy_merge_sync`

## Requirements
- R1: While reset (`rst_n` low) is applied, `cpu_ready_o` is 0. After reset is released, it stays 0 until a qualified request has been synchronized.
- R2: Bus k contributes to the internal request only when `bus_en_n_i[k]` is 0 and `bus_rdy_i[k]` is 1. The request is the OR of all contributing buses. With every enable at 1, the output stays 0.
- R3: With `sync_mode_i` = 0, take a request that rises just after a rising edge. The output is still 0 after the first falling edge that follows, and it becomes 1 at the second falling edge.
- R4: With `sync_mode_i` = 0, take a request that falls just after a rising edge. The output becomes 0 at the first falling edge that follows.
- R5: With `sync_mode_i` = 1, a request change made just after a rising edge appears on the output at the first falling edge that follows, in both directions.
- R6: The mode select may change between bus cycles without a reset. Each falling edge applies the rule of the mode present at that edge: a mode-1 rise is taken at once, and a mode-0 rise still waits for the rising-edge stage.
- R7: `cpu_ready_o` changes only at falling clock edges. Its value is held across rising edges.
- R8: With `bus_en_n_i[1]` tied to 1, the output follows bus 0 alone, whatever `bus_rdy_i[1]` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock; rising and falling edges are both used |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rdy_i | input | NUM_BUS (2) | Ready request from each bus, active high |
| bus_en_n_i | input | NUM_BUS (2) | Per-bus qualifier, active low |
| sync_mode_i | input | 1 | 0 = two-stage path for asynchronous devices, 1 = single-stage path |
| cpu_ready_o | output | 1 | Synchronized ready to the processor |

## Verification
At every falling edge, the assertions check the next-output rules. A low request always clears the output. In mode 1, a high request always sets it. In mode 0, the output is set only when the rising-edge stage already holds the request. With all enables inactive, the output never rises. They also check that both stages are clear while reset is applied. The exact edge counts of R3 and R4 need the bench's timed scenarios to show, as do mode switching in the middle of a transfer, output stability across rising edges, and bus-1 isolation with its enable tied off.

// File: rtl/rdy_sync_pkg.sv
package rdy_sync_pkg;
   typedef enum logic {
      MODE_TWO_STAGE = 1'b0,
      MODE_ONE_STAGE = 1'b1
   } sync_mode_e;

   localparam int MAX_BUS = 8;
endpackage

// File: rtl/rdy_qualify.sv
module rdy_qualify #(
   parameter int NUM_BUS = 2
) (
   input  logic [NUM_BUS-1:0] rdy_i,
   input  logic [NUM_BUS-1:0] en_n_i,
   output logic               req_o
);
   import rdy_sync_pkg::*;

   generate
      if (NUM_BUS < 1 || NUM_BUS > MAX_BUS) begin : g_bad_count
         $error("rdy_qualify: NUM_BUS out of range");
      end

      if (NUM_BUS == 1) begin : g_single
         assign req_o = rdy_i[0] & ~en_n_i[0];
      end else begin : g_multi
         logic [NUM_BUS-1:0] gated;
         for (genvar k = 0; k < NUM_BUS; k++) begin : g_bus
            assign gated[k] = rdy_i[k] & ~en_n_i[k];
         end
         assign req_o = |gated;
      end
   endgenerate
endmodule

// File: rtl/rdy_rise_stage.sv
module rdy_rise_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   output logic stage_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= 1'b0;
      else        stage_q <= req_i;
   end

   // R1: the first stage holds clear during reset
   a_r1_first_clear: assert property (@(posedge clk) !rst_n |-> !stage_q)
      else $error("a_r1_first_clear");
endmodule

// File: rtl/rdy_fall_stage.sv
module rdy_fall_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_i,
   input  logic req_i,
   input  logic early_i,
   output logic ready_q
);
   import rdy_sync_pkg::*;

   sync_mode_e mode;
   logic       nxt;

   assign mode = sync_mode_e'(mode_i);

   always_comb begin
      unique case (mode)
         MODE_ONE_STAGE: nxt = req_i;
         default:        nxt = req_i & early_i;
      endcase
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) ready_q <= 1'b0;
      else        ready_q <= nxt;
   end

   // R4: a dropped request clears ready at the next falling edge in every mode
   a_r4_drop_direct: assert property (@(negedge clk) disable iff (!rst_n)
      !req_i |=> !ready_q) else $error("a_r4_drop_direct");

   // R5: single-stage mode takes a raised request at once
   a_r5_one_stage_rise: assert property (@(negedge clk) disable iff (!rst_n)
      (mode_i && req_i) |=> ready_q) else $error("a_r5_one_stage_rise");

   // R3: two-stage mode sets ready only once the rising-edge stage holds the request
   a_r3_two_stage_wait: assert property (@(negedge clk) disable iff (!rst_n)
      (!mode_i && !early_i) |=> !ready_q) else $error("a_r3_two_stage_wait");

   // R3: two-stage mode with both stages agreeing sets ready
   a_r3_two_stage_set: assert property (@(negedge clk) disable iff (!rst_n)
      (!mode_i && early_i && req_i) |=> ready_q) else $error("a_r3_two_stage_set");

   // R1: the output stage holds clear during reset
   a_r1_out_clear: assert property (@(negedge clk) !rst_n |-> !ready_q)
      else $error("a_r1_out_clear");
endmodule

// File: rtl/rdy_merge_sync.sv
module rdy_merge_sync #(
   parameter int NUM_BUS = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_BUS-1:0] bus_rdy_i,
   input  logic [NUM_BUS-1:0] bus_en_n_i,
   input  logic               sync_mode_i,
   output logic               cpu_ready_o
);
   logic req;
   logic early_q;
   logic ready_q;

   rdy_qualify #(.NUM_BUS(NUM_BUS)) u_qual (
      .rdy_i  (bus_rdy_i),
      .en_n_i (bus_en_n_i),
      .req_o  (req)
   );

   rdy_rise_stage u_rise (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (req),
      .stage_q (early_q)
   );

   rdy_fall_stage u_fall (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode_i  (sync_mode_i),
      .req_i   (req),
      .early_i (early_q),
      .ready_q (ready_q)
   );

   assign cpu_ready_o = ready_q;

   // R2: with every enable inactive the output cannot rise
   a_r2_all_disabled: assert property (@(negedge clk) disable iff (!rst_n)
      (&bus_en_n_i) |=> !cpu_ready_o) else $error("a_r2_all_disabled");

   // R1: output is not-ready while reset is applied
   a_r1_out_low: assert property (@(posedge clk) !rst_n |-> !cpu_ready_o)
      else $error("a_r1_out_low");
endmodule

// File: tb/sim_rdy_merge_sync.sv
module sim_rdy_merge_sync;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] rdy = 2'b00;
   logic [1:0] en_n = 2'b11;
   logic       mode = 1'b0;
   logic       ready;
   int         checks = 0;
   int         errors = 0;

   always #10 clk = ~clk;

   rdy_merge_sync #(.NUM_BUS(2)) u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_rdy_i   (rdy),
      .bus_en_n_i  (en_n),
      .sync_mode_i (mode),
      .cpu_ready_o (ready)
   );

   task automatic check(input string tag, input logic exp);
      checks++;
      if (ready !== exp) begin
         errors++;
         $display("FAIL %s: ready actual %0b expected %0b", tag, ready, exp);
      end
   endtask

   task automatic after_pos(); @(posedge clk); #1; endtask
   task automatic after_neg(); @(negedge clk); #1; endtask

   task automatic drive(input logic [1:0] r, input logic [1:0] e, input logic m);
      after_pos();
      rdy = r; en_n = e; mode = m;
   endtask

   task automatic settle_low(input logic m);
      drive(2'b00, 2'b00, m);
      after_neg(); after_neg();
   endtask

   task automatic t_reset();
      #3;
      check("R1", 1'b0);
      rdy = 2'b11; en_n = 2'b00; mode = 1'b1;
      after_neg();
      check("R1", 1'b0);
      rdy = 2'b00;
      after_pos(); rst_n = 1'b1;
      after_neg();
      check("R1", 1'b0);
   endtask

   task automatic t_async_rise();
      settle_low(1'b0);
      drive(2'b01, 2'b00, 1'b0);
      after_neg(); check("R3", 1'b0);
      after_pos(); check("R7", 1'b0);
      after_neg(); check("R3", 1'b1);
      after_pos(); check("R7", 1'b1);
   endtask

   task automatic t_async_fall();
      drive(2'b01, 2'b00, 1'b0);
      after_neg(); check("R4", 1'b1);
      drive(2'b00, 2'b00, 1'b0);
      after_neg(); check("R4", 1'b0);
   endtask

   task automatic t_sync_edges();
      settle_low(1'b1);
      drive(2'b10, 2'b00, 1'b1);
      after_neg(); check("R5", 1'b1);
      drive(2'b00, 2'b00, 1'b1);
      after_neg(); check("R5", 1'b0);
   endtask

   task automatic t_mode_switch();
      settle_low(1'b0);
      // one-stage rise right after two-stage idle: taken at once
      drive(2'b01, 2'b00, 1'b1);
      after_neg(); check("R6", 1'b1);
      // back to one-stage low, then a two-stage rise must still wait
      drive(2'b00, 2'b00, 1'b1);
      after_neg(); check("R6", 1'b0);
      drive(2'b01, 2'b00, 1'b0);
      after_neg(); check("R6", 1'b0);
      after_neg(); check("R6", 1'b1);
      // switch to one-stage while falling
      drive(2'b00, 2'b00, 1'b1);
      after_neg(); check("R6", 1'b0);
   endtask

   task automatic t_qualify();
      drive(2'b11, 2'b11, 1'b1);
      after_neg(); check("R2", 1'b0);
      drive(2'b01, 2'b10, 1'b1);
      after_neg(); check("R2", 1'b1);
      drive(2'b10, 2'b10, 1'b1);
      after_neg(); check("R2", 1'b0);
      drive(2'b10, 2'b01, 1'b1);
      after_neg(); check("R2", 1'b1);
      drive(2'b01, 2'b01, 1'b1);
      after_neg(); check("R2", 1'b0);
   endtask

   task automatic t_single_bus();
      drive(2'b10, 2'b10, 1'b1);
      after_neg(); check("R8", 1'b0);
      drive(2'b11, 2'b10, 1'b1);
      after_neg(); check("R8", 1'b1);
      drive(2'b01, 2'b10, 1'b1);
      after_neg(); check("R8", 1'b1);
      drive(2'b10, 2'b10, 1'b0);
      after_neg(); check("R8", 1'b0);
      after_neg(); check("R8", 1'b0);
   endtask

   initial begin
      t_reset();
      t_async_rise();
      t_async_fall();
      t_sync_edges();
      t_mode_switch();
      t_qualify();
      t_single_bus();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #4000000;
      errors++;
      $display("FAIL watchdog: ready actual %0b expected run end", ready);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule